// File: doc/BRIEF.md
# Lane-Split Multi-Operand Summing Tree

This block adds a parameterised number of 16-bit operands (anything from none to fifteen) into one 16-bit word. Two run-time enables can cut the word into narrower lanes, and each lane then holds the sum of its own slice of every operand, wrapped to the lane's width. No carry ever crosses an enabled cut. The block suits packed-data arithmetic, where one adder tree serves a full-width sum, two byte sums, or a mix of nibble and byte sums, chosen on each clock.

The operands first go through layers of 3:2 carry-save compressors. Each layer turns every group of three words into two, and passes leftover words straight through, until two words remain. A final ripple adder with carry-kill then produces the result. Every layer, and the final adder, is a stage. A bit mask parameter places an optional pipeline register after any stage. The cut enables travel through the same registers as the data, so a new operand set and a new lane setting can be applied on every clock.

Top module: `addtree_top`

## Requirements
- R1: Lane layout. Lane layout follows `part_en_i`. Bit 0 cuts between bits 3 and 4, and bit 1 cuts between bits 7 and 8. The four settings give these lane masks: 2'b00 gives {FFFF}. 2'b01 gives {FFF0, 000F}. 2'b10 gives {FF00, 00FF}. 2'b11 gives {FF00, 00F0, 000F}. For each lane mask m, the output bits under m equal m AND (the sum over all operands of (operand AND m)).
- R2: Lane carries. A lane's sum wraps at the lane's own width. No carry from a lower lane reaches a higher lane. For example, fifteen operands of 0x000F with setting 2'b01 give 0x0001, and with setting 2'b00 they give 0x00E1.
- R3: Operand count. `N_OPS` may take any value from 0 to 15. With `N_OPS` = 0 the output is always 0.
- R4: Latency. The number of stages is the number of 3:2 layers needed to reach two words, plus one. Bit s of `REG_LEVELS` puts a register after stage s, and bits at or above the stage count must be zero. The latency in clocks equals the number of set bits. With no bits set, the output follows the inputs in the same cycle.
- R5: Throughput. A new operand set is accepted on every clock. Results leave in the order the sets arrived.
- R6: Lane setting in flight. Each result uses the lane setting that was present on the same clock as its operands.
- R7: Reset. An active-low asynchronous reset clears every pipeline register, so a registered output reads 0 until the first result arrives.
- R8: Steady inputs. While the operands and lane setting are held, the output settles after the latency and then does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional stage registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| ops_i | input | max(N_OPS,1)*16 | Operands packed side by side, operand k at bits [16k+15:16k] |
| part_en_i | input | 2 | Lane cut enables: bit 0 cuts at bit 4, bit 1 cuts at bit 8 |
| sum_o | output | 16 | Lane-wise sum |

## Verification
The bench builds three copies of the block. The first has fifteen operands and registers after stages 0, 2 and 6. Its six compressor layers and three-clock latency make it possible to check full-depth carry-save reduction, streaming with the lane setting changed on every clock, and the empty cycles after reset. The second has three operands and no registers, which checks the purely combinational form and a single compressor layer. The third has no operands and one register, which checks the empty-tree case that must always read zero.

// File: rtl/addtree_pkg.sv
`timescale 1ns/1ps
package addtree_pkg;

  // Number of words left after one 3:2 layer acts on n words.
  function automatic int csa_step(input int n);
    return (n > 2) ? (2 * (n / 3) + (n % 3)) : n;
  endfunction

  // Number of 3:2 layers needed to bring n words down to two or fewer.
  function automatic int csa_depth(input int n);
    int c;
    int d;
    c = n;
    d = 0;
    while (c > 2) begin
      c = csa_step(c);
      d++;
    end
    return d;
  endfunction

  // Number of words that enter 3:2 layer number 'layer'.
  function automatic int csa_count(input int n, input int layer);
    int c;
    c = n;
    for (int i = 0; i < layer; i++) c = csa_step(c);
    return c;
  endfunction

  // Number of set bits among the low nbits bits of v.
  function automatic int bit_total(input int v, input int nbits);
    int t;
    t = 0;
    for (int i = 0; i < nbits; i++) t += (v >> i) & 1;
    return t;
  endfunction

endpackage

// File: rtl/addtree_csa_layer.sv
`timescale 1ns/1ps
module addtree_csa_layer #(
  parameter int W      = 16,
  parameter int MAXN   = 15,
  parameter int IN_CNT = 15
) (
  input  logic [MAXN-1:0][W-1:0] ops_i,
  input  logic [W-1:0]           kill_i,
  output logic [MAXN-1:0][W-1:0] ops_o
);
  localparam int GRP = IN_CNT / 3;

  // Majority carries move up one bit. A carry that would enter a cut bit is dropped.
  function automatic logic [W-1:0] part_carry(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [W-1:0] c, input logic [W-1:0] kill);
    logic [W-1:0] maj;
    maj = (a & b) | (a & c) | (b & c);
    return (maj << 1) & ~kill;
  endfunction

  always_comb begin
    ops_o = '0;
    for (int g = 0; g < GRP; g++) begin
      ops_o[2*g]   = ops_i[3*g] ^ ops_i[3*g+1] ^ ops_i[3*g+2];
      ops_o[2*g+1] = part_carry(ops_i[3*g], ops_i[3*g+1], ops_i[3*g+2], kill_i);
    end
    // Words that are not in a full group move down to fill the gap.
    for (int i = 3 * GRP; i < MAXN; i++) ops_o[i-GRP] = ops_i[i];
  end
endmodule

// File: rtl/addtree_final_add.sv
`timescale 1ns/1ps
module addtree_final_add #(
  parameter int W    = 16,
  parameter int MAXN = 15
) (
  input  logic [MAXN-1:0][W-1:0] ops_i,
  input  logic [W-1:0]           kill_i,
  output logic [W-1:0]           sum_o
);
  // Ripple add in which the carry is cleared at every cut bit.
  function automatic logic [W-1:0] part_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] kill);
    logic          cy;
    logic [W-1:0]  s;
    cy = 1'b0;
    s  = '0;
    for (int i = 0; i < W; i++) begin
      if (kill[i]) cy = 1'b0;
      s[i] = a[i] ^ b[i] ^ cy;
      cy   = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  // Only words 0 and 1 can be non-zero here. The words above them are constant
  // zeros and are optimised away.
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < MAXN; i++) sum_o = part_add(sum_o, ops_i[i], kill_i);
  end
endmodule

// File: rtl/addtree_stage_reg.sv
`timescale 1ns/1ps
module addtree_stage_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/addtree_top.sv
`timescale 1ns/1ps
module addtree_top
  import addtree_pkg::*;
#(
  parameter int W          = 16,
  parameter int N_OPS      = 15,
  parameter int LO_CUT     = 4,
  parameter int HI_CUT     = 8,
  parameter int REG_LEVELS = 32'h45
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [((N_OPS>0)?N_OPS:1)*W-1:0]   ops_i,
  input  logic [1:0]                         part_en_i,
  output logic [W-1:0]                       sum_o
);
  localparam int NL   = csa_depth(N_OPS);
  localparam int NS   = NL + 1;
  localparam int MAXN = (N_OPS < 3) ? 3 : N_OPS;

  logic [MAXN-1:0][W-1:0] ops_arr;
  logic [W-1:0]           kill0;
  logic [W-1:0]           fin_kill;
  logic [W-1:0]           sum_q;

  always_comb begin
    ops_arr = '0;
    for (int i = 0; i < N_OPS; i++) ops_arr[i] = ops_i[i*W +: W];
  end

  always_comb begin
    kill0         = '0;
    kill0[LO_CUT] = part_en_i[0];
    kill0[HI_CUT] = part_en_i[1];
  end

  for (genvar s = 0; s < NS; s++) begin : g_st
    localparam bit RB = ((REG_LEVELS >> s) & 1) != 0;
    logic [MAXN-1:0][W-1:0] d_in;
    logic [W-1:0]           k_in;

    if (s == 0) begin : g_src
      assign d_in = ops_arr;
      assign k_in = kill0;
    end else begin : g_lnk
      assign d_in = g_st[s-1].g_csa.d_nx;
      assign k_in = g_st[s-1].g_csa.k_nx;
    end

    if (s < NL) begin : g_csa
      logic [MAXN-1:0][W-1:0] mid;
      logic [MAXN-1:0][W-1:0] d_nx;
      logic [W-1:0]           k_nx;

      addtree_csa_layer #(.W(W), .MAXN(MAXN), .IN_CNT(csa_count(N_OPS, s))) u_lay (
        .ops_i(d_in), .kill_i(k_in), .ops_o(mid));

      if (RB) begin : g_r
        addtree_stage_reg #(.DW(MAXN*W)) u_dreg (
          .clk(clk), .rst_n(rst_n), .d_i(mid), .q_o(d_nx));
        addtree_stage_reg #(.DW(W)) u_kreg (
          .clk(clk), .rst_n(rst_n), .d_i(k_in), .q_o(k_nx));
      end else begin : g_w
        assign d_nx = mid;
        assign k_nx = k_in;
      end
    end else begin : g_fin
      logic [W-1:0] word;

      addtree_final_add #(.W(W), .MAXN(MAXN)) u_add (
        .ops_i(d_in), .kill_i(k_in), .sum_o(word));

      if (RB) begin : g_r
        addtree_stage_reg #(.DW(W)) u_oreg (
          .clk(clk), .rst_n(rst_n), .d_i(word), .q_o(sum_q));
      end else begin : g_w
        assign sum_q = word;
      end
      assign fin_kill = k_in;
    end
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/addtree_chk.sv
`timescale 1ns/1ps
module addtree_chk
  import addtree_pkg::*;
#(
  parameter int W          = 16,
  parameter int N_OPS      = 15,
  parameter int LO_CUT     = 4,
  parameter int HI_CUT     = 8,
  parameter int REG_LEVELS = 32'h45
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [((N_OPS>0)?N_OPS:1)*W-1:0] ops_i,
  input logic [1:0]                       part_en_i,
  input logic [W-1:0]                     sum_o,
  input logic [W-1:0]                     fin_kill
);
  localparam int NL   = csa_depth(N_OPS);
  localparam int NS   = NL + 1;
  localparam int LAT  = bit_total(REG_LEVELS, NS);
  localparam int LATK = bit_total(REG_LEVELS, NL);
  localparam int OW   = ((N_OPS>0)?N_OPS:1)*W;

  logic [OW-1:0] prev_ops;
  logic [1:0]    prev_en;
  logic [7:0]    run;
  logic          held;
  logic [W-1:0]  cut_ref;
  logic          sum_due, kill_due, hold_due;

  assign held = (ops_i == prev_ops) && (part_en_i == prev_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ops <= '0;
      prev_en  <= '0;
      run      <= '0;
    end else begin
      prev_ops <= ops_i;
      prev_en  <= part_en_i;
      run      <= held ? ((run == 8'hFF) ? run : run + 8'd1) : 8'd0;
    end
  end

  always_comb begin
    cut_ref         = '0;
    cut_ref[LO_CUT] = part_en_i[0];
    cut_ref[HI_CUT] = part_en_i[1];
  end

  assign sum_due  = (LAT == 0)  || (held && (int'(run) >= LAT - 1));
  assign kill_due = (LATK == 0) || (held && (int'(run) >= LATK - 1));
  assign hold_due = held && (int'(run) >= LAT);

  // Lane-by-lane reference: find the start of each lane, build its mask, then sum.
  function automatic logic [W-1:0] lane_ref(input logic [OW-1:0] v, input logic [W-1:0] cuts);
    logic [W-1:0] res, m, acc;
    logic         open;
    res = '0;
    for (int lo = 0; lo < W; lo++) begin
      if (lo == 0 || cuts[lo]) begin
        m    = '0;
        open = 1'b1;
        for (int j = lo; j < W; j++) begin
          if (j != lo && cuts[j]) open = 1'b0;
          if (open) m[j] = 1'b1;
        end
        acc = '0;
        for (int i = 0; i < N_OPS; i++) acc = acc + (v[i*W +: W] & m);
        res = res | (acc & m);
      end
    end
    return res;
  endfunction

  // R1
  ref_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_due |-> (sum_o == lane_ref(ops_i, cut_ref)));

  // R6
  part_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_due |-> (fin_kill == cut_ref));

  // R3
  zero_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (N_OPS == 0) |-> (sum_o == '0));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_due |-> $stable(sum_o));
endmodule

bind addtree_top addtree_chk #(
  .W(W), .N_OPS(N_OPS), .LO_CUT(LO_CUT), .HI_CUT(HI_CUT), .REG_LEVELS(REG_LEVELS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ops_i(ops_i), .part_en_i(part_en_i),
  .sum_o(sum_o), .fin_kill(fin_kill)
);

// File: tb/sim_addtree_top.sv
`timescale 1ns/1ps
module sim_addtree_top;
  localparam int W  = 16;
  localparam int N0 = 15;
  localparam int N1 = 3;
  localparam int NV = 12;
  localparam int L0 = 3;   // set bits in 32'h45

  // [18] spread operands, [17:16] lane setting, [15:0] base value
  localparam logic [18:0] TBL [NV] = '{
    {1'b0, 2'b00, 16'h0000}, {1'b0, 2'b00, 16'hFFFF}, {1'b0, 2'b11, 16'hFFFF},
    {1'b0, 2'b00, 16'h0111}, {1'b0, 2'b01, 16'h0111}, {1'b0, 2'b10, 16'h0111},
    {1'b1, 2'b00, 16'h1234}, {1'b1, 2'b01, 16'hABCD}, {1'b1, 2'b10, 16'h5A5A},
    {1'b1, 2'b11, 16'hF00F}, {1'b0, 2'b11, 16'h0111}, {1'b1, 2'b01, 16'h8421}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N0*W-1:0] ops = '0;
  logic [1:0] en = 2'b00;
  logic [W-1:0] sum0, sum1, sum2;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addtree_top #(.W(W), .N_OPS(N0), .REG_LEVELS(32'h45)) u0 (
    .clk(clk), .rst_n(rst_n), .ops_i(ops), .part_en_i(en), .sum_o(sum0));
  addtree_top #(.W(W), .N_OPS(N1), .REG_LEVELS(0)) u_comb (
    .clk(clk), .rst_n(rst_n), .ops_i(ops[N1*W-1:0]), .part_en_i(en), .sum_o(sum1));
  addtree_top #(.W(W), .N_OPS(0), .REG_LEVELS(1)) u_none (
    .clk(clk), .rst_n(rst_n), .ops_i(ops[W-1:0]), .part_en_i(en), .sum_o(sum2));

  // Model built from the mask lists of R1.
  function automatic logic [W-1:0] model(input logic [N0*W-1:0] v, input int cnt, input logic [1:0] e);
    logic [W-1:0] mk [3];
    logic [W-1:0] tot, r;
    int nm;
    mk[0] = '0; mk[1] = '0; mk[2] = '0;
    case (e)
      2'b00:   begin mk[0] = 16'hFFFF; nm = 1; end
      2'b01:   begin mk[0] = 16'hFFF0; mk[1] = 16'h000F; nm = 2; end
      2'b10:   begin mk[0] = 16'hFF00; mk[1] = 16'h00FF; nm = 2; end
      default: begin mk[0] = 16'hFF00; mk[1] = 16'h00F0; mk[2] = 16'h000F; nm = 3; end
    endcase
    r = '0;
    for (int k = 0; k < nm; k++) begin
      tot = '0;
      for (int i = 0; i < cnt; i++) tot = tot + (v[i*W +: W] & mk[k]);
      r = r | (tot & mk[k]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [18:0] ent);
    for (int i = 0; i < N0; i++)
      ops[i*W +: W] = ent[18] ? (ent[15:0] + 16'(i) * 16'h2F1B) : ent[15:0];
    en = ent[17:16];
  endtask

  task automatic fill(input logic [W-1:0] val, input logic [1:0] e);
    for (int i = 0; i < N0; i++) ops[i*W +: W] = val;
    en = e;
  endtask

  initial begin
    logic [W-1:0] exp0 [NV];
    logic [W-1:0] held_v;
    // Reset: apply spread operands with every lane cut.
    apply({1'b1, 2'b11, 16'h9C3E});
    repeat (3) @(negedge clk);
    check("R7 reset clears registered output", sum0, 16'h0000);
    check("R3 zero operands during reset", sum2, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 latency, not ready after 1 clock", sum0, 16'h0000);
    @(negedge clk);
    check("R4 latency, not ready after 2 clocks", sum0, 16'h0000);
    @(negedge clk);
    check("R4 latency, ready after 3 clocks", sum0, model(ops, N0, en));
    @(negedge clk);
    check("R8 output holds under steady inputs", sum0, model(ops, N0, en));

    // Stream one table entry per clock. The lane setting changes every clock.
    for (int k = 0; k < NV + L0; k++) begin
      @(negedge clk);
      if (k >= L0) check("R5/R6 streamed result in order", sum0, exp0[k-L0]);
      if (k < NV) begin
        apply(TBL[k]);
        exp0[k] = model(ops, N0, en);
        #1;
        check("R1 combinational three-operand copy", sum1, model(ops, N1, en));
        check("R3 zero-operand copy reads zero", sum2, 16'h0000);
      end
    end

    // R2: lanes wrap on their own and do not pass carries up.
    @(negedge clk); fill(16'h000F, 2'b01);
    repeat (L0) @(negedge clk);
    check("R2 nibble lane wraps alone", sum0, 16'h0001);
    fill(16'h000F, 2'b00);
    repeat (L0) @(negedge clk);
    check("R2 full lane carries upward", sum0, 16'h00E1);
    fill(16'h000F, 2'b10);
    repeat (L0) @(negedge clk);
    check("R2 byte lane keeps carry", sum0, 16'h00E1);
    fill(16'hFFFF, 2'b11);
    repeat (L0) @(negedge clk);
    check("R2 all ones three lanes", sum0, 16'hF111);
    held_v = sum0;
    repeat (2) @(negedge clk);
    check("R8 steady output two clocks later", sum0, held_v);

    // R4: no registers means the result appears in the same cycle.
    fill(16'hFFFF, 2'b00);
    #1;
    check("R4 zero-latency three-operand sum", sum1, 16'hFFFD);
    fill(16'h0111, 2'b11);
    #1;
    check("R1 three operands of 0x0111 cut three ways", sum1, 16'h0333);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule